// File: doc/BRIEF.md
# Framed Ramp Line Checker

This block sits on the receive side of a framed word stream and judges every frame as good or bad without storing any data. A frame lasts while the vertical sync input is high. Each horizontal sync pulse inside a frame opens a new line. The block follows each line word by word. The first two words of a line are blanking. The third word is a header that carries a data length and a checksum. Every later data word is compared against a running ramp value.

The block keeps two frame slots, ping and pong, in alternation. The active slot index is an output. It changes only when a frame checks good. The ramp value that the next frame must continue from is committed at the same moment. A failed frame leaves both the slot and the ramp value as they were, so the sender can repeat the frame.

Horizontal sync keeps pulsing while vertical sync is idle. Those pulses are not frames and are not errors. A frame whose first line receives no words at all is also an empty frame and produces no report.

Top module: `framed_line_checker`

## Requirements
- R1: After a synchronous active-low reset, `slot_o` is 0 and neither `frame_good_o` nor `frame_err_o` is high. The ramp value expected at the start of the first frame is 0.
- R2: Inside a line, words 0 and 1 are ignored whatever they hold. Word 2 is the header. The header's bits 31:16 are the line's data length. Data words start at word 3. A data valid that comes in the same cycle as the horizontal sync pulse counts as word 0 of the new line.
- R3: A line passes the checksum when header bits 15:8 equal X and header bits 7:0 equal the bitwise inverse of X. X is the XOR of bits 7:0 and bits 15:8 of the first data word. A line with no data word fails the checksum. A checksum failure is reported with `err_kind_o` = 0.
- R4: Only the first LEN data words of a line are compared, where LEN is the header length. Words after them are ignored. A line that ends with fewer than LEN data words is a ramp failure.
- R5: Data word k of a line (k counted from 0) must equal B + k, where B is the line's base ramp value. B for the first line of a frame is the committed ramp value. Each good line adds its LEN to B for the next line. A ramp failure is reported with `err_kind_o` = 1.
- R6: A frame is good when every configured line passes both checks. A good frame gives a one-cycle `frame_good_o` pulse. In the same cycle `slot_o` toggles and the committed ramp value advances by the sum of the frame's lengths.
- R7: A failed frame gives a one-cycle `frame_err_o` pulse. `err_kind_o` and `err_line_o` then describe the first failing line, with lines numbered from 0. The slot and the committed ramp value stay unchanged.
- R8: Syncs and data received while vertical sync is low have no effect. A frame whose line 0 receives no words, or that has no line, is empty: it produces no pulse and changes neither the slot nor the ramp value.
- R9: A non-empty frame that ends with N lines, where N is below `cfg_lines_i`, is a checksum failure with `err_line_o` = N, unless an earlier line already failed.
- R10: Lines beyond the first `cfg_lines_i` lines of a frame are ignored.
- R11: `frame_good_o` and `frame_err_o` are never high together. Either one rises only in the cycle after the edge at which vertical sync is first sampled low, and lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vsync_i | input | 1 | Frame window, high for the whole frame |
| hsync_i | input | 1 | One-cycle pulse that opens a line |
| dvalid_i | input | 1 | `data_i` carries a word this cycle |
| data_i | input | 32 | Stream word |
| cfg_lines_i | input | LINE_W | Lines expected per frame, at least 1, held constant while a frame is open |
| frame_good_o | output | 1 | One-cycle pulse for a good frame |
| frame_err_o | output | 1 | One-cycle pulse for a failed frame |
| err_kind_o | output | 1 | Failure kind: 0 checksum, 1 ramp |
| err_line_o | output | LINE_W | Index of the first failing line |
| slot_o | output | 1 | Active slot: 0 ping, 1 pong |

## Verification
Two judgements can land on the same clock edge. When vertical sync falls, the last open line is closed and judged, and the whole-frame verdict is formed from that result in the same cycle. When a horizontal sync pulse arrives with a valid word, the previous line is judged while the new line takes its word 0. The bench provokes both on purpose. Some frames put the only corrupted line last, right before vertical sync drops. Random frames merge the first blanking word into the sync cycle. The verdict, the reported line and the slot are compared with a bench model that tracks the ramp value, so a mis-ordered close shows up as a wrong kind, a wrong line number or a wrong base in a later frame.

// File: rtl/flc_pkg.sv
// Shared constants and types for the framed ramp line checker.
// Assumes a fixed 32-bit word with the data length in the upper half of the header.
package flc_pkg;
    localparam int WORD_W = 32;
    localparam int LEN_W  = 16;

    typedef enum logic {
        ERR_CKSUM = 1'b0,
        ERR_RAMP  = 1'b1
    } err_kind_e;

    // Condition of the line currently open, as seen by the frame sequencer
    typedef struct packed {
        logic             empty;
        logic             ck_fail;
        logic             ramp_fail;
        logic [LEN_W-1:0] len;
    } line_stat_t;
endpackage

// File: rtl/flc_line_chk.sv
// Follows the words of a single line: skips two blanking words, captures the
// header, checks the checksum on the first data word and compares the data
// words against base_i + index. Assumes base_i is stable while data words arrive.
module flc_line_chk
    import flc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start_i,
    input  logic              word_vld_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [WORD_W-1:0] base_i,
    output line_stat_t        stat_o
);
    logic [1:0]        pos_q, pos_n;
    logic              seen_q, seen_n;
    logic [WORD_W-1:0] hdr_q, hdr_n;
    logic              ck_ok_q, ck_ok_n;
    logic              ramp_bad_q, ramp_bad_n;
    logic [LEN_W:0]    dcnt_q, dcnt_n;

    function automatic logic hdr_matches(input logic [WORD_W-1:0] hdr,
                                         input logic [WORD_W-1:0] first);
        logic [7:0] x;
        x = first[7:0] ^ first[15:8];
        return (hdr[15:8] == x) && (hdr[7:0] == ~x);
    endfunction

    // Next state of the line tracker for this cycle's word
    always_comb begin
        pos_n      = line_start_i ? 2'd0 : pos_q;
        seen_n     = line_start_i ? 1'b0 : seen_q;
        hdr_n      = line_start_i ? '0   : hdr_q;
        ck_ok_n    = line_start_i ? 1'b0 : ck_ok_q;
        ramp_bad_n = line_start_i ? 1'b0 : ramp_bad_q;
        dcnt_n     = line_start_i ? '0   : dcnt_q;
        if (word_vld_i) begin
            seen_n = 1'b1;
            if (pos_n < 2'd2) begin
                pos_n = pos_n + 2'd1;
            end else if (pos_n == 2'd2) begin
                hdr_n = word_i;
                pos_n = 2'd3;
            end else begin
                if (dcnt_n == '0)
                    ck_ok_n = hdr_matches(hdr_n, word_i);
                if ((dcnt_n < {1'b0, hdr_n[WORD_W-1 -: LEN_W]}) &&
                    (word_i != base_i + WORD_W'(dcnt_n)))
                    ramp_bad_n = 1'b1;
                if (dcnt_n != '1)
                    dcnt_n = dcnt_n + 1'b1;
            end
        end
    end

    // Line tracker registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q      <= '0;
            seen_q     <= 1'b0;
            hdr_q      <= '0;
            ck_ok_q    <= 1'b0;
            ramp_bad_q <= 1'b0;
            dcnt_q     <= '0;
        end else begin
            pos_q      <= pos_n;
            seen_q     <= seen_n;
            hdr_q      <= hdr_n;
            ck_ok_q    <= ck_ok_n;
            ramp_bad_q <= ramp_bad_n;
            dcnt_q     <= dcnt_n;
        end
    end

    // Condition presented to the frame sequencer
    always_comb begin
        stat_o.empty     = !seen_q;
        stat_o.len       = hdr_q[WORD_W-1 -: LEN_W];
        stat_o.ck_fail   = (dcnt_q == '0) || !ck_ok_q;
        stat_o.ramp_fail = ramp_bad_q || (dcnt_q < {1'b0, hdr_q[WORD_W-1 -: LEN_W]});
    end

    // R5
    ramp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_bad_q && !line_start_i) |=> ramp_bad_q);

    // R2
    hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == 2'd3 && !line_start_i) |=> $stable(hdr_q));
endmodule

// File: rtl/flc_frame_seq.sv
// Sequences lines within a frame, keeps the first failure and the running ramp
// base, and issues the frame verdict when vertical sync falls.
// Assumes cfg_lines_i >= 1 and constant while vertical sync is high.
module flc_frame_seq
    import flc_pkg::*;
#(
    parameter int LINE_W = 4
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_i,
    input  logic              hsync_i,
    input  logic              dvalid_i,
    input  logic [LINE_W-1:0] cfg_lines_i,
    input  line_stat_t        stat_i,
    input  logic [WORD_W-1:0] ramp_base_i,
    output logic              line_start_o,
    output logic              word_vld_o,
    output logic [WORD_W-1:0] run_base_o,
    output logic              commit_o,
    output logic [WORD_W-1:0] commit_base_o,
    output logic              good_o,
    output logic              err_o,
    output logic              err_kind_o,
    output logic [LINE_W-1:0] err_line_o
);
    localparam int CNT_W = LINE_W + 1;

    logic              vsync_q, line_open_q, fail_q, empty_q;
    logic [LINE_W-1:0] line_idx_q, fline_q;
    err_kind_e         kind_q;
    logic [WORD_W-1:0] run_base_q;
    logic              good_q, err_q, kind_out_q;
    logic [LINE_W-1:0] line_out_q;

    logic              in_frame, sof, eof, counted, closing, judge;
    logic              fail_c, empty_c, frame_real;
    err_kind_e         kind_c;
    logic [LINE_W-1:0] fline_c;
    logic [WORD_W-1:0] base_c;
    logic [CNT_W-1:0]  lines_total, cfg_ext;

    // Frame window edges and the strobes given to the line tracker
    always_comb begin
        in_frame     = vsync_q & vsync_i;
        sof          = vsync_i & ~vsync_q;
        eof          = ~vsync_i & vsync_q;
        line_start_o = in_frame & hsync_i;
        word_vld_o   = in_frame & dvalid_i & (line_open_q | hsync_i);
        counted      = line_idx_q < cfg_lines_i;
        closing      = line_open_q & ((in_frame & hsync_i) | eof);
        judge        = closing & counted & !fail_q & !empty_q;
    end

    // Line judgement and frame verdict
    always_comb begin
        fail_c  = fail_q;
        kind_c  = kind_q;
        fline_c = fline_q;
        empty_c = empty_q;
        base_c  = run_base_q;
        if (judge) begin
            if (stat_i.empty) begin
                if (line_idx_q == '0) begin
                    empty_c = 1'b1;
                end else begin
                    fail_c  = 1'b1;
                    kind_c  = ERR_CKSUM;
                    fline_c = line_idx_q;
                end
            end else if (stat_i.ck_fail) begin
                fail_c  = 1'b1;
                kind_c  = ERR_CKSUM;
                fline_c = line_idx_q;
            end else if (stat_i.ramp_fail) begin
                fail_c  = 1'b1;
                kind_c  = ERR_RAMP;
                fline_c = line_idx_q;
            end else begin
                base_c = run_base_q + WORD_W'(stat_i.len);
            end
        end
        cfg_ext = {1'b0, cfg_lines_i};
        if (!line_open_q)
            lines_total = '0;
        else if (counted)
            lines_total = {1'b0, line_idx_q} + CNT_W'(1);
        else
            lines_total = cfg_ext;
        if (eof && !empty_c && !fail_c && lines_total != '0 && lines_total < cfg_ext) begin
            fail_c  = 1'b1;
            kind_c  = ERR_CKSUM;
            fline_c = lines_total[LINE_W-1:0];
        end
        frame_real    = eof & !empty_c & (lines_total != '0);
        commit_o      = frame_real & !fail_c;
        commit_base_o = base_c;
    end

    // Frame state and registered verdict outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsync_q     <= 1'b0;
            line_open_q <= 1'b0;
            line_idx_q  <= '0;
            fail_q      <= 1'b0;
            kind_q      <= ERR_CKSUM;
            fline_q     <= '0;
            empty_q     <= 1'b0;
            run_base_q  <= '0;
            good_q      <= 1'b0;
            err_q       <= 1'b0;
            kind_out_q  <= 1'b0;
            line_out_q  <= '0;
        end else begin
            vsync_q <= vsync_i;
            good_q  <= commit_o;
            err_q   <= frame_real & fail_c;
            if (frame_real && fail_c) begin
                kind_out_q <= kind_c;
                line_out_q <= fline_c;
            end
            if (sof) begin
                line_open_q <= 1'b0;
                line_idx_q  <= '0;
                fail_q      <= 1'b0;
                empty_q     <= 1'b0;
                run_base_q  <= ramp_base_i;
            end else if (in_frame || eof) begin
                fail_q     <= fail_c;
                kind_q     <= kind_c;
                fline_q    <= fline_c;
                empty_q    <= empty_c;
                run_base_q <= base_c;
                if (in_frame && hsync_i) begin
                    line_open_q <= 1'b1;
                    if (line_open_q && counted)
                        line_idx_q <= line_idx_q + 1'b1;
                end
                if (eof)
                    line_open_q <= 1'b0;
            end
        end
    end

    assign run_base_o = run_base_q;
    assign good_o     = good_q;
    assign err_o      = err_q;
    assign err_kind_o = kind_out_q;
    assign err_line_o = line_out_q;

    // R11
    excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(good_q && err_q));

    // R11
    pulse_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (good_q || err_q) |-> (!vsync_q && $past(vsync_q)));

    // R7
    err_line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (line_out_q < cfg_lines_i));
endmodule

// File: rtl/flc_slot.sv
// Holds the active ping/pong slot and the committed ramp base. Both change only
// on a commit from the frame sequencer.
module flc_slot
    import flc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [WORD_W-1:0] base_i,
    output logic              slot_o,
    output logic [WORD_W-1:0] ramp_base_o
);
    logic              slot_q;
    logic [WORD_W-1:0] base_q;

    // Swap slot and commit the ramp base after a good frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= 1'b0;
            base_q <= '0;
        end else if (commit_i) begin
            slot_q <= ~slot_q;
            base_q <= base_i;
        end
    end

    assign slot_o      = slot_q;
    assign ramp_base_o = base_q;
endmodule

// File: rtl/framed_line_checker.sv
// Top of the framed ramp line checker: line tracker, frame sequencer and
// ping/pong slot keeper. No data storage; verdicts only.
module framed_line_checker
    import flc_pkg::*;
#(
    parameter int LINE_W = 4
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_i,
    input  logic              hsync_i,
    input  logic              dvalid_i,
    input  logic [31:0]       data_i,
    input  logic [LINE_W-1:0] cfg_lines_i,
    output logic              frame_good_o,
    output logic              frame_err_o,
    output logic              err_kind_o,
    output logic [LINE_W-1:0] err_line_o,
    output logic              slot_o
);
    line_stat_t        stat;
    logic              line_start, word_vld, commit;
    logic [WORD_W-1:0] run_base, commit_base, ramp_base;

    flc_line_chk u_line (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_start_i (line_start),
        .word_vld_i   (word_vld),
        .word_i       (data_i),
        .base_i       (run_base),
        .stat_o       (stat)
    );

    flc_frame_seq #(.LINE_W(LINE_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .vsync_i       (vsync_i),
        .hsync_i       (hsync_i),
        .dvalid_i      (dvalid_i),
        .cfg_lines_i   (cfg_lines_i),
        .stat_i        (stat),
        .ramp_base_i   (ramp_base),
        .line_start_o  (line_start),
        .word_vld_o    (word_vld),
        .run_base_o    (run_base),
        .commit_o      (commit),
        .commit_base_o (commit_base),
        .good_o        (frame_good_o),
        .err_o         (frame_err_o),
        .err_kind_o    (err_kind_o),
        .err_line_o    (err_line_o)
    );

    flc_slot u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_i    (commit),
        .base_i      (commit_base),
        .slot_o      (slot_o),
        .ramp_base_o (ramp_base)
    );

    // R6
    slot_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_good_o |-> (slot_o != $past(slot_o)));

    // R7
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |-> $stable(slot_o));
endmodule

// File: tb/framed_line_checker_tb.sv
module framed_line_checker_tb;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vsync = 1'b0, hsync = 1'b0, dvalid = 1'b0;
    logic [31:0]   data = '0;
    logic [LW-1:0] cfg = LW'(2);
    logic          good, err, kind, slot;
    logic [LW-1:0] eline;

    int n_chk = 0, n_fail = 0;
    logic [31:0] exp_base = '0;
    logic        exp_slot = 1'b0;
    int lens [8];

    always #2 clk = ~clk;

    framed_line_checker #(.LINE_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .vsync_i(vsync), .hsync_i(hsync), .dvalid_i(dvalid),
        .data_i(data), .cfg_lines_i(cfg), .frame_good_o(good), .frame_err_o(err),
        .err_kind_o(kind), .err_line_o(eline), .slot_o(slot)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    function automatic logic [31:0] hdr_for(input int len, input logic [31:0] first);
        logic [7:0] x;
        x = first[7:0] ^ first[15:8];
        return {len[15:0], x, ~x};
    endfunction

    // Sends one line. inj: 0 none, 1 checksum, 2 ramp word, 3 short data
    task automatic send_line(input int len, input logic [31:0] base, input int inj,
                             input int pad, input bit merge);
        logic [31:0] w [24];
        int ndata, total, ridx;
        ndata = (len > 0) ? len : 1;
        if (inj == 3) ndata = len - 1;
        ndata += pad;
        if (inj == 3) ndata = len - 1;
        ridx = (len > 0) ? int'($urandom % len) : 0;
        for (int k = 0; k < ndata; k++)
            w[3 + k] = (k < len) ? base + k : $urandom;
        if (inj == 2) w[3 + ridx] = w[3 + ridx] ^ 32'h0000_0100;
        w[0] = $urandom;
        w[1] = $urandom;
        w[2] = hdr_for(len, w[3]);
        if (inj == 1) w[2] = w[2] ^ 32'h1;
        total = 3 + ndata;
        @(negedge clk);
        hsync = 1'b1;
        dvalid = merge;
        data = w[0];
        @(negedge clk);
        hsync = 1'b0;
        dvalid = 1'b0;
        for (int i = merge ? 1 : 0; i < total; i++) begin
            if ($urandom % 4 == 0) begin
                dvalid = 1'b0;
                @(negedge clk);
            end
            dvalid = 1'b1;
            data = w[i];
            @(negedge clk);
        end
        dvalid = 1'b0;
    endtask

    // Runs a frame of nl lines and checks the verdict against the model
    task automatic run_frame(input int nl, input int inj_ln, input int inj_k, input string req);
        logic [31:0] b;
        int counted, sum;
        bit exp_good, exp_err, exp_kind;
        int exp_line;
        @(negedge clk);
        vsync = 1'b1;
        @(negedge clk);
        b = exp_base;
        for (int l = 0; l < nl; l++) begin
            send_line(lens[l], b, (l == inj_ln) ? inj_k : 0, int'($urandom % 3), bit'($urandom % 2));
            b += lens[l];
        end
        counted = (nl < int'(cfg)) ? nl : int'(cfg);
        sum = 0;
        for (int l = 0; l < counted; l++) sum += lens[l];
        exp_good = 0; exp_err = 0; exp_kind = 0; exp_line = 0;
        if (nl == 0) begin
        end else if (inj_k != 0 && inj_ln < counted) begin
            exp_err = 1; exp_kind = (inj_k == 1) ? 1'b0 : 1'b1; exp_line = inj_ln;
        end else if (nl < int'(cfg)) begin
            exp_err = 1; exp_kind = 1'b0; exp_line = nl;
        end else begin
            exp_good = 1;
        end
        vsync = 1'b0;
        @(posedge clk);
        #1;
        chk(req, "good pulse", 64'(good), 64'(exp_good));
        chk(req, "err pulse", 64'(err), 64'(exp_err));
        if (exp_err) begin
            chk(req, "err kind", 64'(kind), 64'(exp_kind));
            chk(req, "err line", 64'(eline), 64'(exp_line));
        end
        if (exp_good) begin
            exp_slot = ~exp_slot;
            exp_base = exp_base + sum;
        end
        chk(req, "slot", 64'(slot), 64'(exp_slot));
        @(posedge clk);
        #1;
        chk("R11", "pulse width", 64'({good, err}), 64'(0));
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", "reset good", 64'(good), 64'(0));
        chk("R1", "reset err", 64'(err), 64'(0));
        chk("R1", "reset slot", 64'(slot), 64'(0));

        // R2 R5 R6: good frames with base carried across frames
        lens[0] = 3; lens[1] = 2;
        run_frame(2, -1, 0, "R6");
        lens[0] = 4; lens[1] = 0;
        run_frame(2, -1, 0, "R5");

        // R3 R7: checksum failure on last line, base not advanced
        lens[0] = 2; lens[1] = 3;
        run_frame(2, 1, 1, "R3");
        run_frame(2, -1, 0, "R7");

        // R5: ramp mismatch on line 0
        lens[0] = 5; lens[1] = 1;
        run_frame(2, 0, 2, "R5");

        // R4: short data line
        lens[0] = 1; lens[1] = 4;
        run_frame(2, 1, 3, "R4");

        // R8: syncs and data with vsync low have no effect
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            hsync = 1'b1; dvalid = 1'b1; data = $urandom;
            @(negedge clk);
            hsync = 1'b0;
            repeat (3) begin data = $urandom; @(negedge clk); end
            dvalid = 1'b0;
        end
        @(posedge clk);
        #1;
        chk("R8", "idle good", 64'(good), 64'(0));
        chk("R8", "idle err", 64'(err), 64'(0));
        chk("R8", "idle slot", 64'(slot), 64'(exp_slot));

        // R8: frame whose line 0 has no words is empty
        @(negedge clk); vsync = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            hsync = 1'b1; @(negedge clk); hsync = 1'b0; repeat (4) @(negedge clk);
        end
        vsync = 1'b0;
        @(posedge clk);
        #1;
        chk("R8", "empty frame good", 64'(good), 64'(0));
        chk("R8", "empty frame err", 64'(err), 64'(0));
        chk("R8", "empty frame slot", 64'(slot), 64'(exp_slot));
        lens[0] = 2; lens[1] = 2;
        run_frame(2, -1, 0, "R8");

        // R9: missing lines
        @(negedge clk); cfg = LW'(3);
        lens[0] = 1; lens[1] = 2;
        run_frame(2, -1, 0, "R9");

        // R10: extra corrupted line beyond the configured count
        lens[0] = 1; lens[1] = 2; lens[2] = 3; lens[3] = 2;
        run_frame(4, 3, 2, "R10");

        // Random frames
        for (int f = 0; f < 60; f++) begin
            int nl, il, ik;
            @(negedge clk);
            cfg = LW'(1 + $urandom % 4);
            nl = int'(cfg) + int'($urandom % 3) - 1;
            for (int l = 0; l < 8; l++) lens[l] = int'($urandom % 7);
            il = int'($urandom % 6);
            ik = ($urandom % 3 == 0) ? 0 : int'(1 + $urandom % 3);
            if (il < 8 && lens[il] < 2) lens[il] = 2;
            run_frame(nl, il, ik, "R5");
        end

        summary();
        $finish;
    end
endmodule